// File: doc/BRIEF.md
# Paged Card Address Decoder

This block turns a host bus address into one device select for a plug-in peripheral card and, for the selected device, the address or register number that device needs. The card answers inside an 8 KB window of a 21-bit host space. Behind the window sit a banked program ROM, a small banked buffer RAM, a floppy disk controller with four registers and a real-time clock with sixteen registers.

The lower seven kilobytes of the window read from ROM. The top kilobyte is buffer RAM, and part of it is overlaid by one of two devices. Which device is chosen by a mode input. With the overlay off, the floppy controller takes a read window and a separate write window. With it on, the clock takes a group of even addresses. ROM and RAM bank numbers, the card enable and the overlay mode are inputs held in a register file outside this block. The decode is pure logic. A parameter can add one output register stage, which is on by default.

Top module: `card_addr_decoder`

## Requirements
- R1: The card window matches when (hostAddr AND 0x7E000) equals 0x74000 with altWindow low, or when (hostAddr AND 0x1FE000) equals 0x174000 with altWindow high. Outside the window, every select is low. The window offset is hostAddr[12:0].
- R2: With cardEnable low, every select is low, whatever the address.
- R3: A read at an offset whose bits 12:10 are not all ones raises romSel, with romAddr = {romPage[1:0], offset[12:0]}. A write at such an offset raises no select.
- R4: In the top kilobyte (offset bits 12:10 all ones), any access that selects neither the controller nor the clock raises ramSel, with ramAddr = {ramPage, offset[9:0]}. Reads and writes are treated the same.
- R5: With clockOverlay low, a read at an even offset from 0x1FF0 to 0x1FF6 raises fdcSel, with fdcReg = offset[2:1].
- R6: With clockOverlay low, a write at an even offset from 0x1FF8 to 0x1FFE raises fdcSel, with fdcReg = offset[2:1]. A read in the write window and a write in the read window go to RAM.
- R7: With clockOverlay high, an access where (offset AND 0x1FE1) equals 0x1FE0 raises rtcSel, with rtcReg = offset[4:1]. fdcSel is never raised in this mode.
- R8: Odd offsets in the controller windows and in the clock window select RAM.
- R9: At most one select is high at a time. Each address or register output is zero while its own select is low.
- R10: With OUT_REG = 1, every output shows the decode of the inputs sampled at the previous rising clock edge. While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 21 | Host address |
| hostRead | input | 1 | 1 = read, 0 = write |
| cardEnable | input | 1 | Card mapped into the host space |
| altWindow | input | 1 | Use the alternate window mask and value |
| romPage | input | 2 | ROM bank number |
| ramPage | input | 1 | RAM bank number |
| clockOverlay | input | 1 | 1 = clock overlays the top kilobyte, 0 = floppy controller does |
| romSel | output | 1 | ROM select |
| ramSel | output | 1 | Buffer RAM select |
| fdcSel | output | 1 | Floppy controller select |
| rtcSel | output | 1 | Real-time clock select |
| romAddr | output | 15 | Physical ROM address |
| ramAddr | output | 11 | Physical RAM address |
| fdcReg | output | 2 | Controller register number |
| rtcReg | output | 4 | Clock register number |

## Verification
Every one of the 8192 window offsets is swept for each combination of direction and overlay mode. The sweep shows where ROM ends and RAM begins, and it catches any offset where two selects are high at once. Directed vectors hit the edges of the controller windows: both window ends, each direction used in the wrong window, and odd addresses. They also hit the edges of the clock group, where a read or write falls through to RAM. This shows the even-only rule and the direction rule apart from the window limits. Seeded random vectors vary the window mode, the card enable and the bank numbers, and include addresses both inside and outside either window. These vectors tell the area match and the gating apart from the offset decode.

// File: rtl/card_dec_pkg.sv
package card_dec_pkg;

  localparam int OFF_W = 13;

  typedef struct packed {
    logic romHit;
    logic ramHit;
    logic fdcHit;
    logic rtcHit;
  } dec_strobe_t;

endpackage

// File: rtl/card_dec_ctrl.sv
module card_dec_ctrl
  import card_dec_pkg::*;
#(
  parameter int          ADDR_W    = 21,
  parameter logic [20:0] STD_MASK  = 21'h07E000,
  parameter logic [20:0] STD_VALUE = 21'h074000,
  parameter logic [20:0] ALT_MASK  = 21'h1FE000,
  parameter logic [20:0] ALT_VALUE = 21'h174000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRead,
  input  logic              cardEnable,
  input  logic              altWindow,
  input  logic              clockOverlay,
  output dec_strobe_t       strobe
);

  localparam logic [OFF_W-1:0] RTC_MASK  = 13'h1FE1;
  localparam logic [OFF_W-1:0] RTC_MATCH = 13'h1FE0;
  localparam logic [9:0]       FDC_RD_HI = 10'h3FE;
  localparam logic [9:0]       FDC_WR_HI = 10'h3FF;

  logic [OFF_W-1:0] offset;
  logic stdHit, altHit, areaHit, active, lastK, evenAddr;
  logic fdcWin, rtcWin;

  assign offset   = hostAddr[OFF_W-1:0];
  assign stdHit   = (hostAddr & STD_MASK[ADDR_W-1:0]) == STD_VALUE[ADDR_W-1:0];
  assign altHit   = (hostAddr & ALT_MASK[ADDR_W-1:0]) == ALT_VALUE[ADDR_W-1:0];
  assign areaHit  = altWindow ? altHit : stdHit;
  assign active   = areaHit & cardEnable;
  assign lastK    = &offset[12:10];
  assign evenAddr = ~offset[0];

  always_comb begin
    fdcWin = hostRead ? (offset[12:3] == FDC_RD_HI) : (offset[12:3] == FDC_WR_HI);
    rtcWin = (offset & RTC_MASK) == RTC_MATCH;
  end

  always_comb begin
    strobe        = '0;
    strobe.romHit = active & ~lastK & hostRead;
    strobe.fdcHit = active & lastK & ~clockOverlay & evenAddr & fdcWin;
    strobe.rtcHit = active & lastK & clockOverlay & rtcWin;
    strobe.ramHit = active & lastK & ~strobe.fdcHit & ~strobe.rtcHit;
  end

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hostRead |-> !strobe.romHit); // R3
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cardEnable |-> (strobe == '0)); // R2
  AST_OVERLAY_NO_FDC: assert property (@(posedge clk) disable iff (!rst_n)
    clockOverlay |-> !strobe.fdcHit); // R7
  AST_FDC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fdcHit |-> !hostAddr[0]); // R5

endmodule

// File: rtl/card_dec_datapath.sv
module card_dec_datapath
  import card_dec_pkg::*;
#(
  parameter int ROM_PAGE_W = 2,
  parameter int RAM_PAGE_W = 1,
  localparam int ROM_A_W   = ROM_PAGE_W + OFF_W,
  localparam int RAM_A_W   = RAM_PAGE_W + 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OFF_W-1:0]      offset,
  input  logic [ROM_PAGE_W-1:0] romPage,
  input  logic [RAM_PAGE_W-1:0] ramPage,
  input  dec_strobe_t           strobe,
  output logic [ROM_A_W-1:0]    romAddr,
  output logic [RAM_A_W-1:0]    ramAddr,
  output logic [1:0]            fdcReg,
  output logic [3:0]            rtcReg
);

  always_comb begin
    romAddr = strobe.romHit ? {romPage, offset} : '0;
    ramAddr = strobe.ramHit ? {ramPage, offset[9:0]} : '0;
    fdcReg  = strobe.fdcHit ? offset[2:1] : '0;
    rtcReg  = strobe.rtcHit ? offset[4:1] : '0;
  end

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.romHit |-> (romAddr == '0)); // R9

endmodule

// File: rtl/card_dec_outreg.sv
module card_dec_outreg
  import card_dec_pkg::*;
#(
  parameter bit OUT_REG = 1,
  parameter int WIDTH   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dec_strobe_t      strobeIn,
  input  logic [WIDTH-1:0] busIn,
  output dec_strobe_t      strobeOut,
  output logic [WIDTH-1:0] busOut
);

  generate
    if (OUT_REG) begin : gRegistered
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          strobeOut <= '0;
          busOut    <= '0;
        end else begin
          strobeOut <= strobeIn;
          busOut    <= busIn;
        end
      end
    end else begin : gDirect
      assign strobeOut = strobeIn;
      assign busOut    = busIn;
    end
  endgenerate

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobeOut)); // R9

endmodule

// File: rtl/card_addr_decoder.sv
module card_addr_decoder
  import card_dec_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int ROM_PAGE_W = 2,
  parameter int RAM_PAGE_W = 1,
  parameter bit OUT_REG    = 1,
  localparam int ROM_A_W   = ROM_PAGE_W + OFF_W,
  localparam int RAM_A_W   = RAM_PAGE_W + 10,
  localparam int BUS_W     = ROM_A_W + RAM_A_W + 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic                  hostRead,
  input  logic                  cardEnable,
  input  logic                  altWindow,
  input  logic [ROM_PAGE_W-1:0] romPage,
  input  logic [RAM_PAGE_W-1:0] ramPage,
  input  logic                  clockOverlay,
  output logic                  romSel,
  output logic                  ramSel,
  output logic                  fdcSel,
  output logic                  rtcSel,
  output logic [ROM_A_W-1:0]    romAddr,
  output logic [RAM_A_W-1:0]    ramAddr,
  output logic [1:0]            fdcReg,
  output logic [3:0]            rtcReg
);

  dec_strobe_t          strobeComb, strobeQ;
  logic [ROM_A_W-1:0]   romAddrC;
  logic [RAM_A_W-1:0]   ramAddrC;
  logic [1:0]           fdcRegC;
  logic [3:0]           rtcRegC;
  logic [BUS_W-1:0]     busQ;

  card_dec_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostRead(hostRead),
    .cardEnable(cardEnable), .altWindow(altWindow),
    .clockOverlay(clockOverlay), .strobe(strobeComb)
  );

  card_dec_datapath #(.ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)) uPath (
    .clk(clk), .rst_n(rst_n), .offset(hostAddr[OFF_W-1:0]),
    .romPage(romPage), .ramPage(ramPage), .strobe(strobeComb),
    .romAddr(romAddrC), .ramAddr(ramAddrC), .fdcReg(fdcRegC), .rtcReg(rtcRegC)
  );

  card_dec_outreg #(.OUT_REG(OUT_REG), .WIDTH(BUS_W)) uOut (
    .clk(clk), .rst_n(rst_n), .strobeIn(strobeComb),
    .busIn({romAddrC, ramAddrC, fdcRegC, rtcRegC}),
    .strobeOut(strobeQ), .busOut(busQ)
  );

  assign romSel = strobeQ.romHit;
  assign ramSel = strobeQ.ramHit;
  assign fdcSel = strobeQ.fdcHit;
  assign rtcSel = strobeQ.rtcHit;
  assign {romAddr, ramAddr, fdcReg, rtcReg} = busQ;

endmodule

// File: tb/card_addr_decoder_test.sv
module card_addr_decoder_test;

  logic clk = 0;
  logic rst_n = 0;
  logic [20:0] hostAddr = '0;
  logic hostRead = 0, cardEnable = 0, altWindow = 0, clockOverlay = 0;
  logic [1:0] romPage = '0;
  logic ramPage = 0;
  logic romSel, ramSel, fdcSel, rtcSel;
  logic [14:0] romAddr;
  logic [10:0] ramAddr;
  logic [1:0] fdcReg;
  logic [3:0] rtcReg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_addr_decoder #(.OUT_REG(1)) uut (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostRead(hostRead),
    .cardEnable(cardEnable), .altWindow(altWindow), .romPage(romPage),
    .ramPage(ramPage), .clockOverlay(clockOverlay),
    .romSel(romSel), .ramSel(ramSel), .fdcSel(fdcSel), .rtcSel(rtcSel),
    .romAddr(romAddr), .ramAddr(ramAddr), .fdcReg(fdcReg), .rtcReg(rtcReg)
  );

  function automatic logic [35:0] model(input logic [20:0] a, input logic rd,
      input logic en, input logic alt, input logic [1:0] rp, input logic mp,
      input logic ov);
    logic [12:0] o;
    logic hit, top, r, m, f, t;
    logic [14:0] ra; logic [10:0] ma; logic [1:0] fr; logic [3:0] tr;
    o = a[12:0];
    hit = en && (alt ? ((a & 21'h1FE000) == 21'h174000)
                     : ((a & 21'h07E000) == 21'h074000));
    top = (o[12:10] == 3'b111);
    r = hit && !top && rd;
    f = hit && top && !ov && !o[0] &&
        (rd ? (o >= 13'h1FF0 && o <= 13'h1FF7) : (o >= 13'h1FF8));
    t = hit && top && ov && !o[0] && (o >= 13'h1FE0);
    m = hit && top && !f && !t;
    ra = r ? {rp, o} : '0;
    ma = m ? {mp, o[9:0]} : '0;
    fr = f ? o[2:1] : '0;
    tr = t ? o[4:1] : '0;
    return {r, m, f, t, ra, ma, fr, tr};
  endfunction

  function automatic logic [35:0] observed();
    return {romSel, ramSel, fdcSel, rtcSel, romAddr, ramAddr, fdcReg, rtcReg};
  endfunction

  task automatic apply(input logic [20:0] a, input logic rd, input logic en,
      input logic alt, input logic [1:0] rp, input logic mp, input logic ov,
      input string req);
    logic [35:0] exp, got;
    @(negedge clk);
    hostAddr = a; hostRead = rd; cardEnable = en; altWindow = alt;
    romPage = rp; ramPage = mp; clockOverlay = ov;
    exp = model(a, rd, en, alt, rp, mp, ov);
    @(posedge clk);
    #1;
    got = observed();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rd=%0d ov=%0d actual=%h expected=%h",
               req, a, rd, ov, got, exp);
    end
    if (countones(got[35:32]) > 1) begin
      errors++;
      $display("FAIL R9 multiple selects actual=%b expected=onehot0", got[35:32]);
    end
  endtask

  function automatic int countones(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  localparam logic [20:0] STD = 21'h074000;
  localparam logic [20:0] ALT = 21'h174000;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    hostAddr = STD | 21'h1FF0; hostRead = 1; cardEnable = 1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (observed() !== '0) begin
      errors++;
      $display("FAIL R10 reset state actual=%h expected=0", observed());
    end
    @(negedge clk); rst_n = 1;

    // R1 window edges, both modes
    apply(STD, 1, 1, 0, 2'd0, 0, 0, "R1");
    apply(STD - 1, 1, 1, 0, 2'd0, 0, 0, "R1");
    apply(STD + 21'h2000, 1, 1, 0, 2'd0, 0, 0, "R1");
    apply(ALT | 21'h0123, 1, 1, 1, 2'd1, 0, 0, "R1");
    apply(STD | 21'h0123, 1, 1, 1, 2'd1, 0, 0, "R1");
    // R2 disabled card
    apply(STD | 21'h0456, 1, 0, 0, 2'd2, 0, 0, "R2");
    apply(STD | 21'h1FF0, 1, 0, 0, 2'd0, 0, 0, "R2");
    // R3 ROM reads, paging, writes ignored
    apply(STD | 21'h1BFF, 1, 1, 0, 2'd3, 1, 0, "R3");
    apply(STD | 21'h0000, 1, 1, 0, 2'd2, 0, 0, "R3");
    apply(STD | 21'h0800, 0, 1, 0, 2'd3, 0, 0, "R3");
    // R4 RAM
    apply(STD | 21'h1C00, 0, 1, 0, 2'd0, 1, 0, "R4");
    apply(STD | 21'h1FEF, 1, 1, 0, 2'd0, 1, 0, "R4");
    // R5 controller read window
    apply(STD | 21'h1FF0, 1, 1, 0, 2'd0, 0, 0, "R5");
    apply(STD | 21'h1FF6, 1, 1, 0, 2'd0, 0, 0, "R5");
    // R6 controller write window and crossings
    apply(STD | 21'h1FF8, 0, 1, 0, 2'd0, 1, 0, "R6");
    apply(STD | 21'h1FFE, 0, 1, 0, 2'd0, 1, 0, "R6");
    apply(STD | 21'h1FF8, 1, 1, 0, 2'd0, 1, 0, "R6");
    apply(STD | 21'h1FF2, 0, 1, 0, 2'd0, 1, 0, "R6");
    // R7 clock overlay
    apply(STD | 21'h1FE0, 1, 1, 0, 2'd0, 0, 1, "R7");
    apply(STD | 21'h1FFE, 0, 1, 0, 2'd0, 0, 1, "R7");
    apply(STD | 21'h1FF0, 1, 1, 0, 2'd0, 0, 1, "R7");
    apply(STD | 21'h1FDE, 1, 1, 0, 2'd0, 1, 1, "R7");
    // R8 odd addresses fall to RAM
    apply(STD | 21'h1FF1, 1, 1, 0, 2'd0, 1, 0, "R8");
    apply(STD | 21'h1FFB, 0, 1, 0, 2'd0, 0, 0, "R8");
    apply(STD | 21'h1FE5, 1, 1, 0, 2'd0, 1, 1, "R8");

    // R9 exhaustive sweep of the window
    for (int ov = 0; ov < 2; ov++)
      for (int rd = 0; rd < 2; rd++)
        for (int o = 0; o < 8192; o++)
          apply(STD | 21'(o), rd[0], 1, 0, 2'(o >> 3), o[4], ov[0], "R9");

    // R1 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [20:0] a;
      int sel;
      sel = int'($urandom_range(0, 2));
      a = 21'($urandom);
      if (sel == 0) a = STD | {8'd0, a[12:0]};
      else if (sel == 1) a = ALT | {8'd0, a[12:0]};
      apply(a, 1'($urandom), ($urandom_range(0, 7) != 0), 1'($urandom),
            2'($urandom), 1'($urandom), 1'($urandom), "R1");
    end

    // R10 reset clears registered outputs
    @(negedge clk);
    hostAddr = STD | 21'h0100; hostRead = 1; cardEnable = 1; altWindow = 0;
    @(posedge clk); #1;
    rst_n = 0; #1;
    checks++;
    if (observed() !== '0) begin
      errors++;
      $display("FAIL R10 async reset actual=%h expected=0", observed());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule